// File: doc/BRIEF.md
# Fully Pipelined Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It accepts a new operand pair on every clock cycle and returns one product per cycle after a fixed latency. Every row of the multiplier array is its own pipeline stage, so each row holds a different operand pair at any moment.

The first stage forms the partial product of the multiplicand with multiplier bit 0. The next N-1 stages are carry-save rows. Each of these adds one more partial product and retires one low product bit. In place of a final carry-propagate adder there are N-1 carry-resolution rows, and each of these moves every pending carry up by exactly one bit position. This keeps every stage to a few gate levels. The multiplier bits shift along with their operand until their row consumes them. Finished low product bits ride along in registers, so that all 2N bits of one product leave together. A valid bit travels with the data.

The latency is 2N-1 cycles: one partial-product stage, N-1 carry-save stages and N-1 carry-resolution stages. A caller streams pairs in with `in_valid` and takes results out with `out_valid`. There is no stall path.

Top module: `amul_pipe_top`

## Requirements
- R1: One clock edge after reset is released, with `in_valid` held low, `out_valid` is 0 and `p` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly 2N-1 rising clock edges, which is 15 at N=8.
- R3: When `out_valid` is 1, `p` equals the unsigned product a*x of the pair that was sampled 2N-1 edges earlier, zero-extended to 2N bits.
- R4: Pairs presented on consecutive cycles each produce their own correct product on consecutive cycles, with no interaction between neighbours.
- R5: Boundary operands give exact results: a zero operand gives a product of 0, and all-ones operands give (2^N-1)^2.
- R6: A cycle with `in_valid` low gives a cycle with `out_valid` low 2N-1 edges later, whatever operand values it carried. The valid products on either side of it are not affected.
- R7: After the k-th carry-resolution row, the pending carry vector has its k lowest bits at zero, and the sum of the sum and carry vectors is unchanged. Products whose upper half needs a carry to travel across all N bits are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a` and `x` is valid this cycle |
| a | input | N | Multiplicand, unsigned |
| x | input | N | Multiplier, unsigned |
| out_valid | output | 1 | `p` holds a valid product this cycle |
| p | output | 2N | Unsigned product |

## Verification
The hardest case to reach from the ports is a carry that has to walk across the whole upper half through the resolution rows. This happens while other pairs sit in every neighbouring stage. The bench reaches it by streaming every one of the 65,536 operand pairs at N=8 back to back, which includes all-ones operands and every carry-chain length, so that every stage is always busy. Separate phases insert idle slots with junk operands between valid pairs, and run a lone pair through an otherwise empty pipeline to pin down the latency.

// File: rtl/amul_pkg.sv
package amul_pkg;

    // Pipeline depth: partial-product stage + carry-save rows + carry rows.
    function automatic int amul_depth(input int n);
        return 1 + (n - 1) + (n - 1);
    endfunction

    // Number of carry-save rows after the partial-product stage.
    function automatic int amul_csa_rows(input int n);
        return n - 1;
    endfunction

    // Number of rows that each move pending carries by one position.
    function automatic int amul_carry_rows(input int n);
        return n - 1;
    endfunction

endpackage

// File: rtl/amul_pp_row.sv
module amul_pp_row #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] x_i,
    output logic         v_o,
    output logic [N-1:0] a_o,
    output logic [N-1:0] x_o,
    output logic [N-1:0] s_o,
    output logic [N-1:0] c_o,
    output logic [N-1:0] lo_o
);
    logic [N-1:0] pp;

    assign pp = a_i & {N{x_i[0]}};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o  <= 1'b0;
            a_o  <= '0;
            x_o  <= '0;
            s_o  <= '0;
            c_o  <= '0;
            lo_o <= '0;
        end else begin
            v_o  <= v_i;
            a_o  <= a_i;
            x_o  <= x_i >> 1;
            s_o  <= pp >> 1;
            c_o  <= '0;
            lo_o <= {{(N-1){1'b0}}, pp[0]};
        end
    end

    p_pp_valid_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v_o == $past(v_i)));

    p_pp_low_bit_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lo_o[0] == $past(a_i[0] & x_i[0])));

endmodule

// File: rtl/amul_csa_row.sv
module amul_csa_row #(
    parameter int N   = 8,
    parameter int ROW = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] s_i,
    input  logic [N-1:0] c_i,
    input  logic [N-1:0] lo_i,
    output logic         v_o,
    output logic [N-1:0] a_o,
    output logic [N-1:0] x_o,
    output logic [N-1:0] s_o,
    output logic [N-1:0] c_o,
    output logic [N-1:0] lo_o
);
    localparam int W2 = N + 2;

    logic [N-1:0] pp;
    logic [N-1:0] t_sum;
    logic [N-1:0] t_cy;
    logic [N-1:0] lo_n;

    // x_i[0] is this row's multiplier bit; the rest moves on shifted down.
    assign pp    = a_i & {N{x_i[0]}};
    assign t_sum = s_i ^ c_i ^ pp;
    assign t_cy  = (s_i & c_i) | (s_i & pp) | (c_i & pp);

    always_comb begin
        lo_n      = lo_i;
        lo_n[ROW] = t_sum[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o  <= 1'b0;
            a_o  <= '0;
            x_o  <= '0;
            s_o  <= '0;
            c_o  <= '0;
            lo_o <= '0;
        end else begin
            v_o  <= v_i;
            a_o  <= a_i;
            x_o  <= x_i >> 1;
            s_o  <= {1'b0, t_sum[N-1:1]};
            c_o  <= t_cy;
            lo_o <= lo_n;
        end
    end

    p_csa_valid_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v_o == $past(v_i)));

    // The retired bit and the new vectors together hold exactly the three inputs.
    p_csa_keeps_value_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((((W2'(s_o) + W2'(c_o)) << 1) + W2'(lo_o[ROW]))
                  == $past(W2'(s_i) + W2'(c_i) + W2'(pp))));

endmodule

// File: rtl/amul_cpr_row.sv
module amul_cpr_row #(
    parameter int N = 8,
    parameter int K = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_i,
    input  logic [N-1:0] s_i,
    input  logic [N-1:0] c_i,
    input  logic [N-1:0] lo_i,
    output logic         v_o,
    output logic [N-1:0] s_o,
    output logic [N-1:0] c_o,
    output logic [N-1:0] lo_o
);
    localparam logic [N-1:0] DONE_MASK = (N'(1) << K) - N'(1);

    logic [N-1:0] gen;

    assign gen = s_i & c_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o  <= 1'b0;
            s_o  <= '0;
            c_o  <= '0;
            lo_o <= '0;
        end else begin
            v_o  <= v_i;
            s_o  <= s_i ^ c_i;
            c_o  <= {gen[N-2:0], 1'b0};
            lo_o <= lo_i;
        end
    end

    p_cpr_valid_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (v_o == $past(v_i)));

    p_carry_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        ((c_o & DONE_MASK) == '0));

    p_carry_sum_kept_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((s_o + c_o) == $past(s_i + c_i)));

    p_low_bits_pass_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lo_o == $past(lo_i)));

endmodule

// File: rtl/amul_pipe_top.sv
module amul_pipe_top #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   x,
    output logic           out_valid,
    output logic [2*N-1:0] p
);
    localparam int D     = amul_pkg::amul_depth(N);
    localparam int NCSA  = amul_pkg::amul_csa_rows(N);
    localparam int NCARY = amul_pkg::amul_carry_rows(N);

    logic         v_q  [D];
    logic [N-1:0] s_q  [D];
    logic [N-1:0] c_q  [D];
    logic [N-1:0] lo_q [D];
    logic [N-1:0] a_q  [N];
    logic [N-1:0] x_q  [N];

    amul_pp_row #(.N(N)) u_pp (
        .clk  (clk),
        .rst  (rst),
        .v_i  (in_valid),
        .a_i  (a),
        .x_i  (x),
        .v_o  (v_q[0]),
        .a_o  (a_q[0]),
        .x_o  (x_q[0]),
        .s_o  (s_q[0]),
        .c_o  (c_q[0]),
        .lo_o (lo_q[0])
    );

    for (genvar r = 1; r <= NCSA; r++) begin : g_csa
        amul_csa_row #(.N(N), .ROW(r)) u_row (
            .clk  (clk),
            .rst  (rst),
            .v_i  (v_q[r-1]),
            .a_i  (a_q[r-1]),
            .x_i  (x_q[r-1]),
            .s_i  (s_q[r-1]),
            .c_i  (c_q[r-1]),
            .lo_i (lo_q[r-1]),
            .v_o  (v_q[r]),
            .a_o  (a_q[r]),
            .x_o  (x_q[r]),
            .s_o  (s_q[r]),
            .c_o  (c_q[r]),
            .lo_o (lo_q[r])
        );
    end

    for (genvar k = 1; k <= NCARY; k++) begin : g_cpr
        amul_cpr_row #(.N(N), .K(k)) u_row (
            .clk  (clk),
            .rst  (rst),
            .v_i  (v_q[NCSA+k-1]),
            .s_i  (s_q[NCSA+k-1]),
            .c_i  (c_q[NCSA+k-1]),
            .lo_i (lo_q[NCSA+k-1]),
            .v_o  (v_q[NCSA+k]),
            .s_o  (s_q[NCSA+k]),
            .c_o  (c_q[NCSA+k]),
            .lo_o (lo_q[NCSA+k])
        );
    end

    // Only the top carry bit can remain; it never meets a set sum bit.
    assign out_valid = v_q[D-1];
    assign p         = {s_q[D-1] ^ c_q[D-1], lo_q[D-1]};

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && (p == '0)));

    p_no_top_collision_r7: assert property (@(posedge clk) disable iff (rst)
        ((s_q[D-1] & c_q[D-1]) == '0));

endmodule

// File: tb/sim_amul_pipe_top.sv
module sim_amul_pipe_top;
    localparam int N    = 8;
    localparam int L    = 2 * N - 1;
    localparam int RING = 32;
    localparam int MAXV = (1 << N) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N-1:0]   a = '0;
    logic [N-1:0]   x = '0;
    logic           out_valid;
    logic [2*N-1:0] p;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic           rv [RING];
    logic [2*N-1:0] rp [RING];
    string          rt [RING];

    always #2ns clk = ~clk;

    amul_pipe_top #(.N(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a         (a),
        .x         (x),
        .out_valid (out_valid),
        .p         (p)
    );

    task automatic step(input logic v, input logic [N-1:0] av,
                        input logic [N-1:0] xv, input string tag);
        int old;
        int slot;
        @(negedge clk);
        old = (cyc + RING - L) % RING;
        checks++;
        if (out_valid !== rv[old]) begin
            fails++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", rt[old], out_valid, rv[old]);
        end else if (rv[old]) begin
            checks++;
            if (p !== rp[old]) begin
                fails++;
                $display("FAIL %s product actual=%0h expected=%0h", rt[old], p, rp[old]);
            end
        end
        slot     = cyc % RING;
        rv[slot] = v;
        rp[slot] = {{N{1'b0}}, av} * {{N{1'b0}}, xv};
        rt[slot] = tag;
        in_valid = v;
        a        = av;
        x        = xv;
        cyc++;
    endtask

    initial begin
        for (int i = 0; i < RING; i++) begin
            rv[i] = 1'b0;
            rp[i] = '0;
            rt[i] = "R2";
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs right after reset
        checks++;
        if (out_valid !== 1'b0 || p !== '0) begin
            fails++;
            $display("FAIL R1 reset actual=%0b/%0h expected=0/0", out_valid, p);
        end

        // R2: lone pair through an empty pipeline, exact latency
        step(1'b1, 8'hB7, 8'h5C, "R2");
        repeat (L + 2) step(1'b0, 8'h00, 8'h00, "R2");

        // R3: a few directed pairs with gaps
        step(1'b1, 8'd13, 8'd11, "R3");
        step(1'b1, 8'd200, 8'd3, "R3");
        step(1'b1, 8'h01, 8'h01, "R3");
        step(1'b0, 8'h00, 8'h00, "R3");

        // R7: long carry chains through the resolution rows
        step(1'b1, 8'hFF, 8'hFF, "R7");
        step(1'b1, 8'hFF, 8'h81, "R7");
        step(1'b1, 8'h81, 8'hFF, "R7");
        step(1'b1, 8'hFE, 8'hFF, "R7");

        // R4/R5: every pair back to back, corners tagged R5
        for (int ai = 0; ai <= MAXV; ai++) begin
            for (int xi = 0; xi <= MAXV; xi++) begin
                if (ai == 0 || xi == 0 || ai == MAXV || xi == MAXV)
                    step(1'b1, N'(ai), N'(xi), "R5");
                else
                    step(1'b1, N'(ai), N'(xi), "R4");
            end
        end

        // R6: idle slots carrying junk operands between valid pairs
        for (int i = 0; i < 48; i++) begin
            step((i % 3) == 0, N'(i * 37 + 5), N'(255 - i * 11), "R6");
        end
        repeat (L + 2) step(1'b0, 8'hFF, 8'hFF, "R6");

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule